// File: doc/BRIEF.md
# Three-Buffer Cyclic Data Exchange Manager

This block tracks which of three shared data buffers each party currently owns for one direction of cyclic traffic. The roles are D (being read or written by the bus side), N (next: parked between the two sides) and U (owned by the user). Each role register holds a buffer index. A rotation swaps the indices of two roles, so no data is ever copied. The buffer memory is outside the block. The block only reports indices and asks the memory owner to zero one buffer when a clear applies.

The flow direction is a parameter. In the output variant, the bus side pushes each received frame from D to N. The user fetches it from N to U and gets a status code that says whether the data are fresh, were cleared, or whether nothing new was waiting. A clear request covers power-up, a master leaving, a global clear command and entry into the wait-for-parameters state. It zeroes the D buffer and pushes it to N, so the user's next fetch reports that the data were cleared. In the input variant, the user commits a filled buffer from U to N. The bus side pulls it from N to D before sending, but only when something new is waiting. The clearable switch turns clearing off for the broadcast buffer set, which rotates the same way.

All control and status pins are plain single-cycle pulses, with no valid/ready handshake. Every request is taken in the cycle it is raised and never stalls, so there is no back-pressure. The read-back path simply follows `idx_u`. That register updates on the same edge that completes a fetch, so a repeated read-back after a fetch is served from the newly fetched buffer.

Top module: `xbm_rotator`

## Requirements
- R1: After reset the roles are D=0, N=1, U=2, no data is marked new, `status_vld` and `zero_req` are low and `cleared_flag` is 0.
- R2: At every clock the three role indices are distinct values in 0..2. A single rotation exchanges exactly two roles and leaves the third unchanged.
- R3: Output variant: a `bus_req` swaps D and N on that clock edge and marks N as holding new, uncleared data.
- R4: Output variant, clearable: `clear_req` raises `zero_req` combinationally in the same cycle, with `zero_idx` equal to the current D index. On the edge, D and N swap, so that index sits in N marked new and cleared.
- R5: Output variant: a `user_req` while N holds new data swaps N and U. The status is 2 (cleared) if that buffer came from a clear and 1 (fresh) otherwise. `cleared_flag` then shows whether U holds a cleared buffer.
- R6: Output variant: a `user_req` while N holds no new data returns status 0 (no new data) and changes no index.
- R7: When a bus-side and a user-side request arrive in the same cycle, the bus-side rotation is applied first. The user-side step then acts on the result.
- R8: Output variant, clearable: `clear_req` together with `bus_req` acts as a clear, so the pushed buffer is marked cleared.
- R9: Input variant: a `bus_req` swaps N and D only when N holds data committed by the user and not yet taken. Otherwise all indices stay unchanged.
- R10: Input variant: a `user_req` swaps U and N and marks N new. The status is 1 (fresh) if N held nothing untaken at that point and 3 (replaced) if an earlier commit was overwritten.
- R11: In the input variant, and in the output variant with clearing disabled, `clear_req` has no effect: `zero_req` stays low and no index changes.
- R12: `status_vld` is high for exactly the one cycle after each `user_req`, with `user_status` valid with it. `idx_u` already shows the new U index in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus-side rotation request (push in output variant, pull in input variant) |
| user_req | input | 1 | User-side command (fetch in output variant, commit in input variant) |
| clear_req | input | 1 | Clear request from start-up, master leave, global clear or wait-for-parameters entry |
| idx_d | output | 2 | Buffer index in role D |
| idx_n | output | 2 | Buffer index in role N |
| idx_u | output | 2 | Buffer index in role U; also selects the read-back buffer |
| status_vld | output | 1 | One-cycle strobe after each user command |
| user_status | output | 2 | 0 no new data, 1 fresh, 2 cleared, 3 replaced |
| cleared_flag | output | 1 | U currently holds a buffer that came from a clear |
| zero_req | output | 1 | Request to zero the buffer at `zero_idx` (same cycle as the clear) |
| zero_idx | output | 2 | Index of the buffer to zero |

## Verification
The bench targets same-cycle collisions. One case pushes and fetches together. Another clears while the user fetches. A third pulls and commits together. A design that ordered the user step first would hand the user an old buffer, or would report no new data where fresh or cleared data is expected. It also fetches twice with no push in between and pulls with nothing committed. A design that ignored the new-data flag would swap there, and the bench would see the indices move. Clear requests are sent to the broadcast and input variants, where a wrongly wired clear would raise `zero_req` or move D. The status of a fetch that follows a clear is checked, and so is the status of a later ordinary push, to catch a stale cleared marker.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  localparam int XBM_NBUF = 3;
  localparam int XBM_IW   = $clog2(XBM_NBUF);

  typedef logic [XBM_IW-1:0] xbm_idx_t;

  typedef enum logic [1:0] {
    XS_NONE     = 2'd0,
    XS_FRESH    = 2'd1,
    XS_CLEARED  = 2'd2,
    XS_REPLACED = 2'd3
  } xbm_stat_e;

  typedef struct packed {
    logic      swap_dn;
    logic      swap_nu;
    logic      nv_nxt;
    logic      nc_nxt;
    logic      uclr_load;
    logic      uclr_val;
    logic      zero;
    xbm_stat_e stat;
  } xbm_plan_t;
endpackage

// File: rtl/xbm_roles.sv
module xbm_roles
  import xbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     swap_dn,
  input  logic     swap_nu,
  output xbm_idx_t idx_d,
  output xbm_idx_t idx_n,
  output xbm_idx_t idx_u
);
  xbm_idx_t d_q, n_q, u_q;
  xbm_idx_t d_mid, n_mid;
  xbm_idx_t d_nxt, n_nxt, u_nxt;

  // First stage: D<->N (bus side), second stage: N<->U (user side)
  always_comb begin
    d_mid = swap_dn ? n_q : d_q;
    n_mid = swap_dn ? d_q : n_q;
    d_nxt = d_mid;
    n_nxt = swap_nu ? u_q   : n_mid;
    u_nxt = swap_nu ? n_mid : u_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= xbm_idx_t'(0);
      n_q <= xbm_idx_t'(1);
      u_q <= xbm_idx_t'(2);
    end else begin
      d_q <= d_nxt;
      n_q <= n_nxt;
      u_q <= u_nxt;
    end
  end

  assign idx_d = d_q;
  assign idx_n = n_q;
  assign idx_u = u_q;

  // R2: roles stay a permutation of the buffer set
  a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (d_q != n_q) && (n_q != u_q) && (d_q != u_q));
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(d_q) < XBM_NBUF) && (int'(n_q) < XBM_NBUF) && (int'(u_q) < XBM_NBUF));
  // R2: a lone bus-side swap leaves U alone and exchanges D and N
  a_r2_dn_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_dn && !swap_nu) |=> ($stable(u_q) && d_q == $past(n_q) && n_q == $past(d_q)));
  // R2: a lone user-side swap leaves D alone
  a_r2_nu_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_dn && swap_nu) |=> ($stable(d_q) && u_q == $past(n_q) && n_q == $past(u_q)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_dn && !swap_nu) |=> ($stable(d_q) && $stable(n_q) && $stable(u_q)));
endmodule

// File: rtl/xbm_sequencer.sv
module xbm_sequencer
  import xbm_pkg::*;
#(
  parameter bit OUT_DIR   = 1'b1,
  parameter bit CLEARABLE = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_req,
  input  logic      user_req,
  input  logic      clear_req,
  output xbm_plan_t plan
);
  logic nvalid_q, ncleared_q;
  xbm_plan_t p_out, p_in;

  // Output direction: bus pushes D->N, user fetches N->U
  always_comb begin
    logic clr, push, nv_mid, nc_mid, ok;
    clr    = clear_req && CLEARABLE;
    push   = clr || bus_req;
    nv_mid = push || nvalid_q;
    nc_mid = push ? clr : ncleared_q;
    ok     = user_req && nv_mid;
    p_out.swap_dn   = push;
    p_out.swap_nu   = ok;
    p_out.nv_nxt    = ok ? 1'b0 : nv_mid;
    p_out.nc_nxt    = ok ? 1'b0 : nc_mid;
    p_out.uclr_load = ok;
    p_out.uclr_val  = nc_mid;
    p_out.zero      = clr;
    if (!ok)         p_out.stat = XS_NONE;
    else if (nc_mid) p_out.stat = XS_CLEARED;
    else             p_out.stat = XS_FRESH;
  end

  // Input direction: user commits U->N, bus pulls N->D when new
  always_comb begin
    logic pull, nv_mid;
    pull   = bus_req && nvalid_q;
    nv_mid = pull ? 1'b0 : nvalid_q;
    p_in.swap_dn   = pull;
    p_in.swap_nu   = user_req;
    p_in.nv_nxt    = user_req ? 1'b1 : nv_mid;
    p_in.nc_nxt    = 1'b0;
    p_in.uclr_load = 1'b0;
    p_in.uclr_val  = 1'b0;
    p_in.zero      = 1'b0;
    p_in.stat      = nv_mid ? XS_REPLACED : XS_FRESH;
  end

  always_comb plan = OUT_DIR ? p_out : p_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvalid_q   <= 1'b0;
      ncleared_q <= 1'b0;
    end else begin
      nvalid_q   <= plan.nv_nxt;
      ncleared_q <= plan.nc_nxt;
    end
  end

  // R9: a bus pull never happens on an empty N (input direction)
  a_r9_pull_needs_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!OUT_DIR && plan.swap_dn) |-> nvalid_q);
  // R6: with nothing new and no push, a fetch never swaps
  a_r6_no_swap_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_DIR && !nvalid_q && !bus_req && !clear_req) |-> !plan.swap_nu);
  // R11: no clear activity where clearing is off
  a_r11_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!OUT_DIR || !CLEARABLE) |-> !plan.zero);
endmodule

// File: rtl/xbm_status.sv
module xbm_status
  import xbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      user_req,
  input  xbm_plan_t plan,
  output logic      status_vld,
  output xbm_stat_e user_status,
  output logic      cleared_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_vld   <= 1'b0;
      user_status  <= XS_NONE;
      cleared_flag <= 1'b0;
    end else begin
      status_vld <= user_req;
      if (user_req)       user_status  <= plan.stat;
      if (plan.uclr_load) cleared_flag <= plan.uclr_val;
    end
  end

  // R12: strobe only follows a user command
  a_r12_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    status_vld |-> $past(user_req));
  // R5: a cleared status is always accompanied by the cleared flag
  a_r5_flag_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && user_status == XS_CLEARED) |-> cleared_flag);
endmodule

// File: rtl/xbm_rotator.sv
module xbm_rotator
  import xbm_pkg::*;
#(
  parameter bit OUT_DIR   = 1'b1,
  parameter bit CLEARABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       user_req,
  input  logic       clear_req,
  output logic [1:0] idx_d,
  output logic [1:0] idx_n,
  output logic [1:0] idx_u,
  output logic       status_vld,
  output logic [1:0] user_status,
  output logic       cleared_flag,
  output logic       zero_req,
  output logic [1:0] zero_idx
);
  xbm_plan_t plan;
  xbm_stat_e stat_q;
  xbm_idx_t  d_i, n_i, u_i;

  xbm_sequencer #(.OUT_DIR(OUT_DIR), .CLEARABLE(CLEARABLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .user_req(user_req),
    .clear_req(clear_req), .plan(plan)
  );

  xbm_roles u_roles (
    .clk(clk), .rst_n(rst_n), .swap_dn(plan.swap_dn), .swap_nu(plan.swap_nu),
    .idx_d(d_i), .idx_n(n_i), .idx_u(u_i)
  );

  xbm_status u_stat (
    .clk(clk), .rst_n(rst_n), .user_req(user_req), .plan(plan),
    .status_vld(status_vld), .user_status(stat_q), .cleared_flag(cleared_flag)
  );

  assign idx_d       = d_i;
  assign idx_n       = n_i;
  assign idx_u       = u_i;
  assign user_status = stat_q;
  assign zero_req    = plan.zero;
  assign zero_idx    = d_i;

  // R4: the zeroed buffer lands in N after a clear (no fetch in the same cycle)
  a_r4_zeroed_to_n: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req && !user_req) |=> (idx_n == $past(zero_idx)));
  // R6: a no-data status leaves U where it was
  a_r6_none_keeps_u: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && user_status == XS_NONE) |-> $stable(idx_u));
endmodule

// File: tb/sim_xbm_rotator.sv
module sim_xbm_rotator;
  localparam int TCK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic b0 = 0, q0 = 0, c0 = 0;
  logic b1 = 0, q1 = 0, c1 = 0;
  logic b2 = 0, q2 = 0, c2 = 0;
  logic [1:0] d[3], n[3], u[3], st[3], zi[3];
  logic       sv[3], cf[3], zr[3];
  int nvec = 0, nerr = 0;
  int zr_seen, zi_seen;

  xbm_rotator #(.OUT_DIR(1'b1), .CLEARABLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(b0), .user_req(q0), .clear_req(c0),
    .idx_d(d[0]), .idx_n(n[0]), .idx_u(u[0]), .status_vld(sv[0]),
    .user_status(st[0]), .cleared_flag(cf[0]), .zero_req(zr[0]), .zero_idx(zi[0]));
  xbm_rotator #(.OUT_DIR(1'b1), .CLEARABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_req(b1), .user_req(q1), .clear_req(c1),
    .idx_d(d[1]), .idx_n(n[1]), .idx_u(u[1]), .status_vld(sv[1]),
    .user_status(st[1]), .cleared_flag(cf[1]), .zero_req(zr[1]), .zero_idx(zi[1]));
  xbm_rotator #(.OUT_DIR(1'b0), .CLEARABLE(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_req(b2), .user_req(q2), .clear_req(c2),
    .idx_d(d[2]), .idx_n(n[2]), .idx_u(u[2]), .status_vld(sv[2]),
    .user_status(st[2]), .cleared_flag(cf[2]), .zero_req(zr[2]), .zero_idx(zi[2]));

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one-cycle pulse on instance k; zero_req sampled mid-cycle, outputs at next negedge
  task automatic step(input int k, input logic b, input logic q, input logic c);
    @(negedge clk);
    case (k)
      0: begin b0 = b; q0 = q; c0 = c; end
      1: begin b1 = b; q1 = q; c1 = c; end
      default: begin b2 = b; q2 = q; c2 = c; end
    endcase
    #1;
    zr_seen = int'(zr[k]);
    zi_seen = int'(zi[k]);
    @(negedge clk);
    b0 = 0; q0 = 0; c0 = 0; b1 = 0; q1 = 0; c1 = 0; b2 = 0; q2 = 0; c2 = 0;
  endtask

  task automatic exp_roles(input int k, input string tag, input int ed, input int en, input int eu);
    chk({tag, " idx_d"}, int'(d[k]), ed);
    chk({tag, " idx_n"}, int'(n[k]), en);
    chk({tag, " idx_u"}, int'(u[k]), eu);
    chk("R2 permutation", int'(d[k] != n[k] && n[k] != u[k] && d[k] != u[k]), 1);
  endtask

  task automatic exp_stat(input int k, input string tag, input int es);
    chk({tag, " status_vld"}, int'(sv[k]), 1);
    chk({tag, " user_status"}, int'(st[k]), es);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      exp_roles(k, "R1 reset", 0, 1, 2);
      chk("R1 reset status_vld", int'(sv[k]), 0);
      chk("R1 reset zero_req", int'(zr[k]), 0);
      chk("R1 reset cleared_flag", int'(cf[k]), 0);
    end
  endtask

  task automatic t_out_main();
    step(0, 0, 1, 0);                       // fetch with nothing new
    exp_stat(0, "R6 empty fetch", 0);
    exp_roles(0, "R6 empty fetch", 0, 1, 2);
    step(0, 0, 0, 1);                       // clear
    chk("R4 zero_req", zr_seen, 1);
    chk("R4 zero_idx", zi_seen, 0);
    exp_roles(0, "R4 clear", 1, 0, 2);
    chk("R12 strobe one cycle", int'(sv[0]), 0);
    step(0, 0, 1, 0);                       // fetch cleared buffer
    exp_stat(0, "R5 cleared fetch", 2);
    exp_roles(0, "R5 cleared fetch", 1, 2, 0);
    chk("R5 cleared_flag set", int'(cf[0]), 1);
    step(0, 1, 0, 0);                       // push
    exp_roles(0, "R3 push", 2, 1, 0);
    chk("R3 no zero on push", zr_seen, 0);
    step(0, 0, 1, 0);                       // fetch fresh
    exp_stat(0, "R5 fresh fetch", 1);
    exp_roles(0, "R12 read-back follows U", 2, 0, 1);
    chk("R5 cleared_flag dropped", int'(cf[0]), 0);
  endtask

  task automatic t_out_collide();
    step(0, 1, 1, 0);                       // push and fetch together
    exp_stat(0, "R7 push+fetch", 1);
    exp_roles(0, "R7 push+fetch", 0, 1, 2);
    step(0, 0, 1, 0);
    exp_stat(0, "R6 refetch", 0);
    exp_roles(0, "R6 refetch", 0, 1, 2);
    step(0, 1, 0, 1);                       // clear and push together
    chk("R8 zero_idx", zi_seen, 0);
    exp_roles(0, "R8 clear+push", 1, 0, 2);
    step(0, 0, 1, 0);
    exp_stat(0, "R8 clear wins", 2);
    exp_roles(0, "R8 fetch", 1, 2, 0);
    step(0, 0, 1, 1);                       // clear and fetch together
    chk("R7 clear+fetch zero_idx", zi_seen, 1);
    exp_stat(0, "R7 clear+fetch", 2);
    exp_roles(0, "R7 clear+fetch", 2, 0, 1);
    chk("R7 cleared_flag", int'(cf[0]), 1);
  endtask

  task automatic t_broadcast();
    step(1, 0, 0, 1);
    chk("R11 bcast zero_req", zr_seen, 0);
    exp_roles(1, "R11 bcast clear", 0, 1, 2);
    step(1, 1, 0, 0);
    exp_roles(1, "R3 bcast push", 1, 0, 2);
    step(1, 0, 1, 0);
    exp_stat(1, "R5 bcast fetch", 1);
    exp_roles(1, "R5 bcast fetch", 1, 2, 0);
    step(1, 0, 1, 1);
    exp_stat(1, "R11 bcast clear+fetch", 0);
    exp_roles(1, "R11 bcast clear+fetch", 1, 2, 0);
  endtask

  task automatic t_input();
    step(2, 1, 0, 0);
    exp_roles(2, "R9 empty pull", 0, 1, 2);
    step(2, 0, 1, 0);
    exp_stat(2, "R10 commit", 1);
    exp_roles(2, "R10 commit", 0, 2, 1);
    step(2, 0, 1, 0);
    exp_stat(2, "R10 replace", 3);
    exp_roles(2, "R10 replace", 0, 1, 2);
    step(2, 1, 0, 0);
    exp_roles(2, "R9 pull", 1, 0, 2);
    step(2, 1, 0, 0);
    exp_roles(2, "R9 second pull", 1, 0, 2);
    step(2, 0, 0, 1);
    chk("R11 input zero_req", zr_seen, 0);
    exp_roles(2, "R11 input clear", 1, 0, 2);
    step(2, 0, 1, 0);
    exp_roles(2, "R10 commit2", 1, 2, 0);
    step(2, 1, 1, 0);
    exp_stat(2, "R7 pull+commit", 1);
    exp_roles(2, "R7 pull+commit", 2, 0, 1);
  endtask

  initial begin
    #(TCK * 100000);
    nerr++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_main();
    t_out_collide();
    t_broadcast();
    t_input();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule